// File: doc/BRIEF.md
# Global History Correlating Direction Predictor

This block predicts whether a conditional branch will be taken by combining a shift register of recent branch outcomes with the low bits of the branch address. Together they select one saturating counter from a single pattern table. The history register records the outcome of every resolved branch. Because it can be read in parallel, the pattern of the last few outcomes picks among several counters for the same address. A run-time mode input chooses how the history and the address are combined. Concatenation gives every history value its own set of entries. XOR folds the history into the address bits, so it needs fewer entries but lets more branches alias.

A front-end stage presents a fetch address on the lookup port and gets a prediction back in the same cycle. A back-end stage reports resolved branches in program order, at most one per clock, on the resolution port. Each resolution trains the counter that was selected and then shifts its outcome into the history. Both changes take effect at the same clock edge.

Top module: `gcorr_predictor`

## Requirements
- R1: Reset (active-low `rst_n`) sets `ghist` to zero and every counter to zero, so every lookup predicts not taken (`lk_taken` = 0).
- R2: Each resolution with `rs_valid` = 1 shifts `rs_taken` into bit 0 of `ghist` and drops the top bit. Bit value 1 means taken and 0 means not taken. With 4 history bits, the outcomes taken, not taken, taken, taken, not taken leave `ghist` at 0001, 0010, 0101, 1011 and then 0110.
- R3: While `rs_valid` = 0, the values on `rs_pc` and `rs_taken` change neither `ghist` nor any counter.
- R4: With `xor_mode` = 0, the entry index is {ghist, pc[S-1:0]}, with the history in the upper bits.
- R5: With `xor_mode` = 1, the entry index is pc[S-1:0] XOR ghist, with the history zero-extended to S bits. This requires P ≤ S. As a result, (pc 1, history 00) and (pc 0, history 01) share one entry, and so does (pc 2, history 11).
- R6: A counter of N bits predicts taken when its value is at least 2^(N-1). A taken outcome increments it and a not-taken outcome decrements it. It holds at 2^N−1 and at 0 instead of wrapping.
- R7: A resolution trains the entry indexed by the history as it stood before that resolution. A lookup made in the same cycle as a resolution sees both the counters and the history from before that resolution.
- R8: A change of `xor_mode` clears every counter at the next edge but keeps `ghist`. The new mode takes effect for lookups from that edge on. A resolution in that same cycle shifts the history but trains no counter.
- R9: When one branch alternates taken and not taken with 2 history bits, every prediction is correct after a warm-up of a few occurrences.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xor_mode | input | 1 | Index function: 0 concatenate, 1 XOR |
| lk_pc | input | PC_W | Address of the branch being looked up |
| lk_taken | output | 1 | Same-cycle prediction, 1 = taken |
| rs_valid | input | 1 | A resolved branch is presented this cycle |
| rs_pc | input | PC_W | Address of the resolved branch |
| rs_taken | input | 1 | Actual outcome, 1 = taken |
| ghist | output | P | Global outcome history, newest in bit 0 |

## Verification
A lookup and a resolution can fall in the same cycle. The bench provokes this on every resolution it drives by putting the same address on both ports. It samples the prediction just before the edge and judges it against a reference model that has not yet taken the update. It then samples again after the edge and judges against the model with the update applied. The same overlap is exercised when a resolution coincides with a mode change, and there the bench checks that the history moves while the counters stay cleared.

// File: rtl/gcorr_predictor.sv
module gcorr_predictor #(
  parameter int PC_W = 16,
  parameter int S    = 4,
  parameter int P    = 2,
  parameter int N    = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            xor_mode,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_taken,
  output logic [P-1:0]    ghist
);

  localparam int IW  = S + P;
  localparam int ENT = 1 << IW;
  localparam logic [N-1:0] MAXC = '1;

  logic [ENT-1:0][N-1:0] tbl;
  logic                  mode_q;
  logic                  clr;
  logic [IW-1:0]         lk_idx, rs_idx;
  logic [N-1:0]          cur, nxt;

  function automatic logic [IW-1:0] index_of(input logic [P-1:0] h,
                                             input logic [S-1:0] pc,
                                             input logic x);
    logic [S-1:0] hx;
    hx = S'(h);
    return x ? IW'(pc ^ hx) : {h, pc};
  endfunction

  assign clr      = (mode_q != xor_mode);
  assign lk_idx   = index_of(ghist, lk_pc[S-1:0], mode_q);
  assign rs_idx   = index_of(ghist, rs_pc[S-1:0], mode_q);
  assign lk_taken = tbl[lk_idx][N-1];
  assign cur      = tbl[rs_idx];

  always_comb begin
    if (rs_taken) nxt = (cur == MAXC) ? cur : cur + N'(1);
    else          nxt = (cur == '0)   ? cur : cur - N'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl    <= '0;
      ghist  <= '0;
      mode_q <= 1'b0;
    end else begin
      mode_q <= xor_mode;
      if (clr)           tbl         <= '0;
      else if (rs_valid) tbl[rs_idx] <= nxt;
      if (rs_valid)      ghist       <= P'({ghist, rs_taken});
    end
  end

endmodule

// File: rtl/gcorr_predictor_chk.sv
module gcorr_predictor_chk #(
  parameter int S = 4,
  parameter int P = 2,
  parameter int N = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          xor_mode,
  input logic                          mode_q,
  input logic                          rs_valid,
  input logic                          rs_taken,
  input logic [S+P-1:0]                rs_idx,
  input logic [P-1:0]                  ghist,
  input logic [(1<<(S+P))-1:0][N-1:0]  tbl
);
  localparam logic [N-1:0] MAXC = '1;

  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (ghist == '0 && tbl == '0)); // R1

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |=> ghist == P'({$past(ghist), $past(rs_taken)})); // R2

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |=> $stable(ghist)); // R3

  AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_taken && mode_q == xor_mode && tbl[rs_idx] == MAXC)
    |=> tbl[$past(rs_idx)] == MAXC); // R6

  AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_taken && mode_q == xor_mode && tbl[rs_idx] == '0)
    |=> tbl[$past(rs_idx)] == '0); // R6

  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != xor_mode) |=> tbl == '0); // R8
endmodule

bind gcorr_predictor gcorr_predictor_chk #(.S(S), .P(P), .N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .xor_mode(xor_mode), .mode_q(mode_q),
  .rs_valid(rs_valid), .rs_taken(rs_taken), .rs_idx(rs_idx),
  .ghist(ghist), .tbl(tbl)
);

// File: tb/gcorr_predictor_test.sv
module gcorr_predictor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xor_mode = 1'b0;
  logic [15:0] lk_pc = '0;
  logic        rs_valid = 1'b0;
  logic [15:0] rs_pc = '0;
  logic        rs_taken = 1'b0;
  logic        lk_taken, lk_taken4;
  logic [1:0]  ghist;
  logic [3:0]  ghist4;

  int checks = 0;
  int fails  = 0;

  int       mtbl[64];
  logic [1:0] mh;
  logic     mmode;

  always #2 clk = ~clk;

  gcorr_predictor #(.PC_W(16), .S(4), .P(2), .N(2)) uut (
    .clk(clk), .rst_n(rst_n), .xor_mode(xor_mode), .lk_pc(lk_pc),
    .lk_taken(lk_taken), .rs_valid(rs_valid), .rs_pc(rs_pc),
    .rs_taken(rs_taken), .ghist(ghist));

  gcorr_predictor #(.PC_W(16), .S(4), .P(4), .N(2)) uut4 (
    .clk(clk), .rst_n(rst_n), .xor_mode(xor_mode), .lk_pc(lk_pc),
    .lk_taken(lk_taken4), .rs_valid(rs_valid), .rs_pc(rs_pc),
    .rs_taken(rs_taken), .ghist(ghist4));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int midx(logic [15:0] pc);
    if (mmode) return int'({2'b00, mh} ^ pc[3:0]);
    return int'({mh, pc[3:0]});
  endfunction

  function automatic int mpred(logic [15:0] pc);
    return (mtbl[midx(pc)] >= 2) ? 1 : 0;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; xor_mode = 1'b0; rs_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    foreach (mtbl[i]) mtbl[i] = 0;
    mh = '0; mmode = 1'b0;
  endtask

  task automatic set_mode(logic m);
    @(negedge clk);
    xor_mode = m;
    if (m != mmode) foreach (mtbl[i]) mtbl[i] = 0;
    mmode = m;
  endtask

  // Resolution with a same-cycle lookup of the same address (R7).
  task automatic resolve(logic [15:0] pc, logic t, string tag);
    int i;
    @(negedge clk);
    rs_valid = 1'b1; rs_pc = pc; rs_taken = t; lk_pc = pc;
    #1 check({tag, " R7 pre-edge"}, lk_taken, mpred(pc));
    i = midx(pc);
    if (t) mtbl[i] = (mtbl[i] == 3) ? 3 : mtbl[i] + 1;
    else   mtbl[i] = (mtbl[i] == 0) ? 0 : mtbl[i] - 1;
    mh = {mh[0], t};
    @(negedge clk);
    rs_valid = 1'b0;
    #1 check({tag, " R7 post-edge"}, lk_taken, mpred(pc));
  endtask

  task automatic look(logic [15:0] pc, int exp, string tag);
    @(negedge clk);
    lk_pc = pc;
    #1 check(tag, lk_taken, exp);
  endtask

  task automatic t_reset();
    do_reset();
    #1 check("R1 history", ghist, 0);
    for (int p = 0; p < 16; p++) look(16'(p * 3), 0, "R1 lookup");
  endtask

  task automatic t_history();
    logic [4:0] seq = 5'b10110;
    int exp4[5] = '{1, 2, 5, 11, 6};
    do_reset();
    for (int k = 0; k < 5; k++) begin
      resolve(16'h0010, seq[4-k], "R2");
      check("R2 history P=4", ghist4, exp4[k]);
      check("R2 history P=2", ghist, exp4[k] & 3);
    end
  endtask

  task automatic t_idle();
    logic [1:0] h0;
    do_reset();
    for (int k = 0; k < 7; k++) resolve(16'h0005, 1'b1, "R3 train");
    h0 = ghist;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      rs_valid = 1'b0; rs_pc = 16'(k); rs_taken = k[0];
    end
    @(negedge clk);
    #1 check("R3 history held", ghist, h0);
    look(16'h0005, 1, "R3 counter kept");
    for (int k = 0; k < 6; k++) look(16'(k == 5 ? 0 : k), 0, "R3 others");
  endtask

  task automatic t_index();
    do_reset();
    resolve(16'h0001, 1'b1, "R4");
    resolve(16'h0000, 1'b1, "R4");
    look(16'h0002, 0, "R4 concat no alias");
    do_reset();
    set_mode(1'b1);
    resolve(16'h0001, 1'b1, "R5");
    resolve(16'h0000, 1'b1, "R5");
    look(16'h0002, 1, "R5 xor alias");
  endtask

  task automatic t_saturate();
    do_reset();
    for (int k = 0; k < 7; k++) resolve(16'h0007, 1'b1, "R6 up");
    resolve(16'h0007, 1'b0, "R6");
    resolve(16'h0007, 1'b1, "R6");
    resolve(16'h0007, 1'b1, "R6");
    look(16'h0007, 1, "R6 top saturation");
    do_reset();
    resolve(16'h0009, 1'b0, "R6 down");
    mh = 2'b00;
    @(negedge clk);
    rs_valid = 1'b1; rs_pc = 16'h0009; rs_taken = 1'b0;
    @(negedge clk);
    rs_valid = 1'b0;
    do_reset_hist_free();
  endtask

  // After two not-taken resolutions history is 00 again, entry {00,9}.
  task automatic do_reset_hist_free();
    look(16'h0009, 0, "R6 bottom saturation");
    check("R6 history", ghist, 0);
  endtask

  task automatic t_mode_clear();
    do_reset();
    for (int k = 0; k < 7; k++) resolve(16'h0004, 1'b1, "R8 train");
    look(16'h0004, 1, "R8 trained");
    @(negedge clk);
    xor_mode = 1'b1; rs_valid = 1'b1; rs_pc = 16'h0004; rs_taken = 1'b0;
    @(negedge clk);
    rs_valid = 1'b0; xor_mode = 1'b0;
    @(negedge clk);
    #1 check("R8 history kept and shifted", ghist, 2);
    for (int k = 0; k < 16; k++) look(16'(k), 0, "R8 cleared");
    foreach (mtbl[i]) mtbl[i] = 0;
    mh = 2'b10; mmode = 1'b0;
  endtask

  task automatic t_alternate();
    int ok = 0;
    do_reset();
    for (int k = 0; k < 24; k++) begin
      logic t = (k % 2 == 0);
      @(negedge clk);
      lk_pc = 16'h002A;
      #1;
      if (k >= 6) begin
        check("R9 alternating prediction", lk_taken, t);
        if (lk_taken == t) ok++;
      end
      resolve(16'h002A, t, "R9");
    end
    check("R9 accuracy after warm-up", ok, 18);
  endtask

  task automatic t_model(logic m, string tag);
    logic [7:0] lf = 8'hA5;
    do_reset();
    set_mode(m);
    for (int k = 0; k < 48; k++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      resolve(16'(lf[2:0]), lf[6] | lf[1], tag);
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_history();
    t_idle();
    t_index();
    t_saturate();
    t_mode_clear();
    t_alternate();
    t_model(1'b0, "R4 model");
    t_model(1'b1, "R5 model");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule